// File: doc/BRIEF.md
# Serial Divide-by-Three Remainder Tracker

This block receives an unsigned binary number one bit per clock, most significant bit first, and keeps the remainder of the value received so far when divided by three. Each accepted bit doubles the value seen so far and adds the new bit. The new remainder therefore follows from the old remainder and the incoming bit alone, and the number can be any length. A bit is accepted only on cycles where the valid strobe is high. A synchronous reset starts a new number by clearing the remainder to zero.

The remainder is held in a three-state register, one state per remainder value. A combinational step function feeds the register from the old state and the input bit. A parameter selects the output form. In the registered (Moore) form the output is the stored state, so an accepted bit shows up on the output one clock later. In the transition (Mealy) form the output already includes the bit offered in the current cycle.

Top module: `mod3_serial_rem`

## Requirements
- R1: A synchronous reset sets the stored remainder to 0 and takes priority over a valid bit in the same cycle. After reset, both output forms show 0 while the valid strobe is low.
- R2: On a clock edge where the valid strobe is high and reset is low, the stored remainder becomes (2 × old remainder + input bit) mod 3.
- R3: On a clock edge where the valid strobe is low, the stored remainder is unchanged, whatever the value of the input bit.
- R4: With the parameter IS_MEALY = 0, the 2-bit output is the stored remainder. It changes only on the clock edge after an accepted bit or after a reset.
- R5: With IS_MEALY = 1, the output in a cycle where the valid strobe is high is the remainder that includes the current input bit. When the valid strobe is low, the output is the stored remainder.
- R6: The output is always a binary 0, 1 or 2 and never the code 3.
- R7: The first bit received is the most significant. The stream 0,1,0,1,0 (decimal 10) makes the registered output step through 0,1,2,2,1.
- R8: There is no length limit. After a stream of up to 64 bits, the output equals the full value mod 3, including streams of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | High when inBit carries a bit of the number |
| inBit | input | 1 | Serial data bit, most significant first |
| remOut | output | 2 | Remainder of the value so far divided by three |

## Verification
The hardest case to reach from the ports is a long stream with gaps, where bits offered while the valid strobe is low must leave no trace. This matters most for the transition form, whose output mixes the stored state with the live input. The stimulus therefore interleaves idle cycles that carry random data bits into random streams of up to 64 bits. Both output forms are compared every cycle against a behavioural remainder and, at the end of each stream, against the full 64-bit value mod 3. A reset issued while a valid one bit is offered checks that reset takes priority over the valid strobe.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int REM_W = 2;

  typedef enum logic [REM_W-1:0] {
    REM0 = 2'd0,
    REM1 = 2'd1,
    REM2 = 2'd2
  } remState_t;

  typedef struct packed {
    logic clear;
    logic advance;
  } ctrlStrobe_t;

  // Remainder after appending one bit below the current value.
  function automatic remState_t stepRem(input remState_t cur, input logic b);
    remState_t nxt;
    case (cur)
      REM0:    nxt = b ? REM1 : REM0;
      REM1:    nxt = b ? REM0 : REM2;
      REM2:    nxt = b ? REM2 : REM1;
      default: nxt = REM0;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/mod3_ctrl.sv
module mod3_ctrl
  import mod3_pkg::*;
(
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t ctrl
);
  // Reset wins over an accepted bit.
  always_comb begin
    ctrl.clear   = rst;
    ctrl.advance = inValid & ~rst;
  end
endmodule

// File: rtl/mod3_datapath.sv
module mod3_datapath
  import mod3_pkg::*;
#(
  parameter bit IS_MEALY = 1'b0
) (
  input  logic             clk,
  input  ctrlStrobe_t      ctrl,
  input  logic             inBit,
  output logic [REM_W-1:0] curRem,
  output logic [REM_W-1:0] remOut
);
  remState_t stateQ;
  remState_t stateNext;

  always_comb stateNext = stepRem(stateQ, inBit);

  always_ff @(posedge clk) begin
    if (ctrl.clear)        stateQ <= REM0;
    else if (ctrl.advance) stateQ <= stateNext;
  end

  assign curRem = stateQ;

  generate
    if (IS_MEALY) begin : g_transition
      assign remOut = ctrl.advance ? stateNext : stateQ;
    end else begin : g_registered
      assign remOut = stateQ;
    end
  endgenerate
endmodule

// File: rtl/mod3_serial_rem.sv
module mod3_serial_rem
  import mod3_pkg::*;
#(
  parameter bit IS_MEALY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inBit,
  output logic [REM_W-1:0] remOut
);
  ctrlStrobe_t      ctrl;
  logic [REM_W-1:0] curRem;

  mod3_ctrl ctrl_i (
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  mod3_datapath #(.IS_MEALY(IS_MEALY)) dp_i (
    .clk    (clk),
    .ctrl   (ctrl),
    .inBit  (inBit),
    .curRem (curRem),
    .remOut (remOut)
  );
endmodule

// File: rtl/mod3_chk.sv
module mod3_chk #(
  parameter bit IS_MEALY = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       inBit,
  input logic [1:0] remOut,
  input logic [1:0] curRem
);
  function automatic logic [1:0] arithRem(input logic [1:0] r, input logic b);
    int v;
    v = (2 * int'(r) + int'(b)) % 3;
    return v[1:0];
  endfunction

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> curRem == 2'd0);

  // R2
  step_rule_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> curRem == arithRem($past(curRem), $past(inBit)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(curRem));

  // R6
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    remOut != 2'd3);

  generate
    if (IS_MEALY) begin : g_trans_chk
      // R5
      mealy_live_chk: assert property (@(posedge clk) disable iff (rst)
        inValid |-> remOut == arithRem(curRem, inBit));
      // R5
      mealy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !inValid |-> remOut == curRem);
    end else begin : g_reg_chk
      // R4
      moore_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(remOut) |-> ($past(inValid) || $past(rst)));
    end
  endgenerate
endmodule

bind mod3_serial_rem mod3_chk #(.IS_MEALY(IS_MEALY)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inBit   (inBit),
  .remOut  (remOut),
  .curRem  (curRem)
);

// File: tb/mod3_serial_rem_tb_top.sv
module mod3_serial_rem_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       inBit = 1'b0;
  logic [1:0] mooreOut;
  logic [1:0] mealyOut;

  int checks = 0;
  int fails = 0;
  int refRem = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mod3_serial_rem #(.IS_MEALY(1'b0)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit), .remOut(mooreOut)
  );

  mod3_serial_rem #(.IS_MEALY(1'b1)) dutMealy_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit), .remOut(mealyOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // R1: reset while a valid one bit is offered
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; inBit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    refRem = 0;
    #1;
    check("R1 moore", mooreOut, 0);
    check("R1 mealy", mealyOut, 0);
  endtask

  task automatic step(input logic v, input logic b);
    int nxt;
    @(negedge clk);
    inValid = v; inBit = b;
    nxt = v ? (2 * refRem + int'(b)) % 3 : refRem;
    #1;
    check("R5 mealy", mealyOut, nxt);
    check("R4 moore before edge", mooreOut, refRem);
    @(posedge clk);
    refRem = nxt;
    #1;
    if (v) check("R2 moore", mooreOut, refRem);
    else   check("R3 moore", mooreOut, refRem);
    check("R6 code", int'(mooreOut != 2'd3 && mealyOut != 2'd3), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seq [5];
    int expSeq [5];
    longint unsigned val;
    int len;

    doReset();

    // R7: MSB-first stream 0,1,0,1,0 = ten
    seq = '{0, 1, 0, 1, 0};
    expSeq = '{0, 1, 2, 2, 1};
    for (int i = 0; i < 5; i++) begin
      step(1'b1, seq[i][0]);
      check("R7 sequence", mooreOut, expSeq[i]);
    end

    // R3: idle cycles with data toggling
    for (int i = 0; i < 4; i++) step(1'b0, i[0]);
    check("R3 idle keeps ten", mooreOut, 1);

    // R1: reset from a nonzero remainder
    doReset();

    // R8: 64 ones, 2^64-1 is divisible by three
    for (int i = 0; i < 64; i++) step(1'b1, 1'b1);
    check("R8 all ones", mooreOut, 0);

    // R8: random streams with random gaps
    for (int s = 0; s < 30; s++) begin
      doReset();
      len = 1 + ($urandom % 64);
      val = 0;
      for (int i = 0; i < len; i++) begin
        logic b;
        b = 1'($urandom);
        if (($urandom % 4) == 0) step(1'b0, ~b);
        step(1'b1, b);
        val = (val << 1) | longint'(b);
      end
      step(1'b0, 1'b1);
      check("R8 stream value", mooreOut, int'(val % 64'd3));
      check("R8 stream mealy", mealyOut, int'(val % 64'd3));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule